// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the target side of a byte-wide serial memory on a two-wire bus. The system clock samples the clock line and the data line. The block recognises the bus conditions on those lines and answers the controller by pulling the data line low through an open-drain enable. A transaction opens with a device-address byte. The upper four bits of that byte are fixed and the next three must equal the strap pins. A write-mode transaction then carries a two-byte word address and zero or more data bytes. A read-mode transaction streams bytes out for as long as the controller acknowledges them.

Write data collects in a page-sized staging buffer. A stop condition moves the buffer into the byte array during a self-timed programming cycle of `WR_CYCLES` clocks. While that cycle runs the target ignores the bus, so a controller can poll with address bytes until one is acknowledged. A write-protect input blocks the programming cycle without disturbing the handshake. The array holds `2**ADDR_W` bytes: `ADDR_W = 13` gives 8192 bytes, and the default keeps elaboration light.

An internal address counter survives between transactions. During writes it advances only within the current page. During reads it advances across the whole array.

Top module: `tw_mem_target`

## Requirements
- R1: A falling data line while the clock line is high opens a transaction, and a rising data line while the clock line is high ends it and releases the data line. The target changes its own drive only after the clock line falls.
- R2: The device-address byte is matched MSB first as bits 7..4 = 1010, bits 3..1 = `strap_i[2:0]`, and bit 0 = 1 for read or 0 for write. On a match the target pulls the data line low during the ninth clock. On a mismatch it gives no acknowledge, and it ignores every further byte until the next start.
- R3: After a write-mode address, the target acknowledges two word-address bytes, high byte first. Only the low `ADDR_W` bits of the 16-bit value are used.
- R4: Each data byte is acknowledged and stored at the next offset in a page of `2**PAGE_W` bytes. Only the low `PAGE_W` address bits advance, so byte number `2**PAGE_W + 1` overwrites the first one.
- R5: A stop that follows at least one data byte starts a programming cycle of `WR_CYCLES` clocks. While it runs, no address byte is acknowledged. Afterwards the target answers again and the new data reads back.
- R6: If `wp_i` is high at the stop, the data bytes are still acknowledged, but no programming cycle starts and the array keeps its old contents.
- R7: The address counter keeps its value between transactions. A read-mode address with no preceding word address returns the byte at the last accessed address plus one.
- R8: A read continues with the next byte while the controller acknowledges. After the last array byte it continues at address 0. A missing acknowledge ends it.
- R9: A write-mode address plus word address, then a repeated start and a read-mode address, reads from the loaded word address.
- R10: A write transaction that carries no data byte only loads the address counter and starts no programming cycle.
- R11: Data bytes followed by a repeated start instead of a stop are discarded.
- R12: After reset the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling both bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired level) |
| strap_i | input | 3 | Device-address strap pins |
| wp_i | input | 1 | Write protect, high blocks programming |
| sda_oe_o | output | 1 | Pull data line low when high |

## Verification
The checker covers the behaviours that hold on every cycle:
- the drive is turned on only after a clock-line fall;
- the line is released after every stop;
- the data line stays released for the whole programming cycle;
- array writes occur only inside that cycle;
- no cycle ever starts while write protect was high at the stop.

Address matching, the two kinds of wrap-around, the persistence of the counter, and the discard of data on a repeated start only show up as byte values read back over the bus. The bench scenarios compare those values against its own model of the array and the counter.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_HI,
        ST_LO,
        ST_WDAT,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_SKIP
    } tw_state_e;

    // Where the acknowledge phase hands over once the ninth clock ends.
    typedef enum logic [1:0] {
        NX_HI,
        NX_LO,
        NX_WDAT,
        NX_TX
    } tw_next_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } tw_line_t;

    function automatic logic dev_match(input logic [6:0] dev, input logic [2:0] strap);
        return (dev[6:3] == DEV_PREFIX) && (dev[2:0] == strap);
    endfunction

endpackage

// File: rtl/tw_line_monitor.sv
module tw_line_monitor import tw_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output tw_line_t line_o
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_q;
    logic                   sda_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= scl_i;
                    sda_sync <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
                    sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_sync[TOP];
            sda_q <= sda_sync[TOP];
        end
    end

    always_comb begin
        line_o.sda      = sda_sync[TOP];
        line_o.scl_rise = scl_sync[TOP] & ~scl_q;
        line_o.scl_fall = ~scl_sync[TOP] & scl_q;
        line_o.start    = scl_sync[TOP] & scl_q & sda_q & ~sda_sync[TOP];
        line_o.stop     = scl_sync[TOP] & scl_q & ~sda_q & sda_sync[TOP];
    end

endmodule

// File: rtl/tw_page_buffer.sv
module tw_page_buffer #(
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_off,
    input  logic [7:0]        wr_data,
    input  logic [PAGE_W-1:0] rd_off,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    localparam int SLOTS = 1 << PAGE_W;

    logic [SLOTS-1:0] valid_vec;
    logic [7:0]       data_arr [SLOTS];

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            logic       v;
            logic [7:0] d;
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    v <= 1'b0;
                end else if (wr_en && wr_off == PAGE_W'(g)) begin
                    v <= 1'b1;
                end
                if (wr_en && wr_off == PAGE_W'(g)) begin
                    d <= wr_data;
                end
            end
            assign valid_vec[g] = v;
            assign data_arr[g]  = d;
        end
    endgenerate

    assign rd_valid = valid_vec[rd_off];
    assign rd_data  = data_arr[rd_off];

endmodule

// File: rtl/tw_write_timer.sv
module tw_write_timer #(
    parameter int CYCLES = 2000,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    output logic              busy,
    output logic              commit_en,
    output logic [PAGE_W-1:0] commit_idx
);
    localparam int SLOTS = 1 << PAGE_W;
    localparam int SPAN  = (CYCLES > SLOTS) ? CYCLES : SLOTS;
    localparam int CW    = $clog2(SPAN + 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (go && !run) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (run) begin
            if (cnt == CW'(SPAN - 1)) begin
                run <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign busy       = run;
    assign commit_en  = run && (cnt < CW'(SLOTS));
    assign commit_idx = cnt[PAGE_W-1:0];

endmodule

// File: rtl/tw_byte_store.sv
module tw_byte_store #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/tw_mem_target.sv
module tw_mem_target import tw_pkg::*; #(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int WR_CYCLES   = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);
    tw_line_t           line;
    tw_state_e          state;
    tw_next_e           after;
    logic [7:0]         shreg;
    logic [7:0]         hi_byte;
    logic [7:0]         txbyte;
    logic [3:0]         bcnt;
    logic [ADDR_W-1:0]  addr;
    logic               write_pending;
    logic               mst_ack;
    logic               oe;

    logic               wr_busy;
    logic               commit_en;
    logic [PAGE_W-1:0]  commit_idx;
    logic               slot_valid;
    logic [7:0]         slot_data;
    logic [7:0]         rd_byte;

    logic               rx_state;
    logic               byte_done;
    logic               buf_we;
    logic               buf_clr;
    logic               wr_go;
    logic               store_we;
    logic [ADDR_W-1:0]  store_addr;

    tw_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .line_o (line)
    );

    always_comb begin
        rx_state   = (state == ST_DEV) || (state == ST_HI) ||
                     (state == ST_LO)  || (state == ST_WDAT);
        byte_done  = rx_state && line.scl_fall && (bcnt == 4'd8);
        buf_we     = byte_done && (state == ST_WDAT);
        buf_clr    = line.start && !wr_busy;
        wr_go      = line.stop && write_pending && !wp_i && !wr_busy;
        store_we   = commit_en && slot_valid;
        store_addr = {addr[ADDR_W-1:PAGE_W], commit_idx};
    end

    tw_page_buffer #(.PAGE_W(PAGE_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .clr      (buf_clr),
        .wr_en    (buf_we),
        .wr_off   (addr[PAGE_W-1:0]),
        .wr_data  (shreg),
        .rd_off   (commit_idx),
        .rd_valid (slot_valid),
        .rd_data  (slot_data)
    );

    tw_write_timer #(.CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .go         (wr_go),
        .busy       (wr_busy),
        .commit_en  (commit_en),
        .commit_idx (commit_idx)
    );

    tw_byte_store #(.ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (store_we),
        .waddr (store_addr),
        .wdata (slot_data),
        .raddr (addr),
        .rdata (rd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            after         <= NX_HI;
            shreg         <= '0;
            hi_byte       <= '0;
            txbyte        <= '0;
            bcnt          <= '0;
            addr          <= '0;
            write_pending <= 1'b0;
            mst_ack       <= 1'b0;
            oe            <= 1'b0;
        end else if (line.start) begin
            state         <= ST_DEV;
            bcnt          <= '0;
            oe            <= 1'b0;
            write_pending <= 1'b0;
        end else if (line.stop) begin
            state         <= ST_IDLE;
            oe            <= 1'b0;
            write_pending <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_HI, ST_LO, ST_WDAT: begin
                    if (line.scl_rise && bcnt != 4'd8) begin
                        shreg <= {shreg[6:0], line.sda};
                        bcnt  <= bcnt + 4'd1;
                    end else if (byte_done) begin
                        bcnt <= '0;
                        case (state)
                            ST_DEV: begin
                                if (!wr_busy && dev_match(shreg[7:1], strap_i)) begin
                                    oe    <= 1'b1;
                                    state <= ST_ACK;
                                    after <= shreg[0] ? NX_TX : NX_HI;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end
                            ST_HI: begin
                                hi_byte <= shreg;
                                oe      <= 1'b1;
                                state   <= ST_ACK;
                                after   <= NX_LO;
                            end
                            ST_LO: begin
                                addr  <= ADDR_W'({hi_byte, shreg});
                                oe    <= 1'b1;
                                state <= ST_ACK;
                                after <= NX_WDAT;
                            end
                            default: begin
                                addr          <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
                                write_pending <= 1'b1;
                                oe            <= 1'b1;
                                state         <= ST_ACK;
                                after         <= NX_WDAT;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (line.scl_fall) begin
                        oe <= 1'b0;
                        case (after)
                            NX_HI:   state <= ST_HI;
                            NX_LO:   state <= ST_LO;
                            NX_WDAT: state <= ST_WDAT;
                            default: begin
                                state  <= ST_TX;
                                txbyte <= rd_byte;
                                oe     <= ~rd_byte[7];
                                addr   <= addr + 1'b1;
                                bcnt   <= '0;
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (line.scl_fall) begin
                        if (bcnt == 4'd7) begin
                            oe      <= 1'b0;
                            bcnt    <= '0;
                            mst_ack <= 1'b0;
                            state   <= ST_RACK;
                        end else begin
                            bcnt   <= bcnt + 4'd1;
                            txbyte <= {txbyte[6:0], 1'b0};
                            oe     <= ~txbyte[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (line.scl_rise) begin
                        mst_ack <= ~line.sda;
                    end else if (line.scl_fall) begin
                        if (mst_ack) begin
                            state  <= ST_TX;
                            txbyte <= rd_byte;
                            oe     <= ~rd_byte[7];
                            addr   <= addr + 1'b1;
                            bcnt   <= '0;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o = oe;

endmodule

// File: rtl/tw_mem_target_chk.sv
module tw_mem_target_chk (
    input logic clk,
    input logic rst,
    input logic wp_i,
    input logic sda_oe,
    input logic scl_fall,
    input logic stop_seen,
    input logic busy,
    input logic store_we
);
    AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(scl_fall)); // R1

    AST_RELEASE_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !sda_oe); // R1

    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe); // R5

    AST_STORE_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
        store_we |-> busy); // R5

    AST_PROTECT_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(wp_i)); // R6

endmodule

bind tw_mem_target tw_mem_target_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wp_i      (wp_i),
    .sda_oe    (sda_oe_o),
    .scl_fall  (line.scl_fall),
    .stop_seen (line.stop),
    .busy      (wr_busy),
    .store_we  (store_we)
);

// File: tb/tw_mem_target_test.sv
module tw_mem_target_test;
    localparam int AW  = 11;
    localparam int PW  = 5;
    localparam int WRC = 600;
    localparam int Q   = 8;
    localparam int DEPTH = 1 << AW;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       wp = 1'b0;
    logic       oe;
    wire        sda_line = sda_m & ~oe;

    always #2.5 clk = ~clk;

    tw_mem_target #(.ADDR_W(AW), .PAGE_W(PW), .WR_CYCLES(WRC)) uut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .strap_i  (strap),
        .wp_i     (wp),
        .sda_oe_o (oe)
    );

    int         errs = 0;
    int         checks = 0;
    bit         done = 0;
    logic [7:0] model [DEPTH];
    logic [AW-1:0] mptr = '0;
    logic [7:0] wbuf [40];
    logic [7:0] rbuf [40];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    function automatic logic [AW-1:0] page_next(input logic [AW-1:0] a);
        return {a[AW-1:PW], a[PW-1:0] + 1'b1};
    endfunction

    function automatic logic [7:0] dev(input bit rd);
        return {4'b1010, strap, rd};
    endfunction

    task automatic t_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic t_stop();
        scl_m = 1'b0; sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        ack = (sda_line == 1'b0);
        wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wq(); scl_m = 1'b1; wq();
            b = {b[6:0], sda_line};
            wq(); scl_m = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1;
        wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    // Address phase of a write-mode transaction; returns 1 if all three bytes were acknowledged.
    task automatic addr_phase(input logic [15:0] word, output bit ok);
        bit a;
        ok = 1;
        t_start();
        send_byte(dev(0), a); ok &= a;
        send_byte(word[15:8], a); ok &= a;
        send_byte(word[7:0], a); ok &= a;
    endtask

    task automatic write_tx(input logic [AW-1:0] at, input int n, output bit ok);
        bit a;
        logic [AW-1:0] p;
        addr_phase(16'(at), ok);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); ok &= a;
        end
        t_stop();
        p = at;
        for (int i = 0; i < n; i++) begin
            if (!wp) model[p] = wbuf[i];
            p = page_next(p);
        end
        mptr = p;
    endtask

    task automatic read_body(input int n);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, rbuf[i]);
        end
        t_stop();
    endtask

    task automatic rand_read(input logic [AW-1:0] at, input int n, output bit ok);
        bit a;
        addr_phase(16'(at), ok);
        t_start();
        send_byte(dev(1), a); ok &= a;
        read_body(n);
        mptr = at + AW'(n);
    endtask

    task automatic wait_ready();
        bit a;
        for (int i = 0; i < 30; i++) begin
            t_start(); send_byte(dev(0), a); t_stop();
            if (a) return;
        end
        chk(0, "R5 device never became ready", 0, 1);
    endtask

    task automatic cmp_read(input logic [AW-1:0] at, input int n, input string req);
        logic [AW-1:0] p;
        p = at;
        for (int i = 0; i < n; i++) begin
            chk(rbuf[i] === model[p], req, int'(rbuf[i]), int'(model[p]));
            p = p + 1'b1;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired R5 actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : main
        bit ok, a;
        int unused;
        logic [7:0] b;
        unused = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(oe == 1'b0, "R12 line released after reset", int'(oe), 0);

        // R2: wrong strap, then wrong prefix; later bytes ignored
        t_start();
        send_byte({4'b1010, ~strap, 1'b0}, a);
        chk(!a, "R2 strap mismatch gets no ack", a, 0);
        send_byte(8'h00, a);
        chk(!a, "R2 bytes ignored after mismatch", a, 0);
        t_stop();
        chk(oe == 1'b0, "R1 line released after stop", int'(oe), 0);
        t_start();
        send_byte({4'b1011, strap, 1'b0}, a);
        chk(!a, "R2 prefix mismatch gets no ack", a, 0);
        t_stop();

        // R3/R5/R9: byte write, busy polling, random read
        wbuf[0] = 8'h5A;
        write_tx(11'h123, 1, ok);
        chk(ok, "R3 address and data acknowledged", ok, 1);
        t_start(); send_byte(dev(0), a); t_stop();
        chk(!a, "R5 no ack during write cycle", a, 0);
        wait_ready();
        rand_read(11'h123, 1, ok);
        chk(ok, "R9 random read acks", ok, 1);
        cmp_read(11'h123, 1, "R9 random read data");

        // R3: upper word-address bits ignored
        addr_phase(16'hF9AB, ok);
        send_byte(8'hC3, a); t_stop();
        model[11'h1AB] = 8'hC3;
        wait_ready();
        rand_read(11'h1AB, 1, ok);
        cmp_read(11'h1AB, 1, "R3 high word-address bits dropped");

        // R4: page write of 35 bytes starting at offset 3
        for (int i = 0; i < 35; i++) wbuf[i] = 8'(8'h80 + i);
        write_tx(11'h043, 35, ok);
        chk(ok, "R4 all page bytes acked", ok, 1);
        wait_ready();
        rand_read(11'h043, 1, ok);
        chk(rbuf[0] == 8'(8'h80 + 32), "R4 33rd byte overwrote first", int'(rbuf[0]), 8'h80 + 32);
        // R7: current-address read after the random read
        t_start(); send_byte(dev(1), a); read_body(1);
        chk(a, "R7 current read acked", a, 1);
        chk(rbuf[0] === model[11'h044], "R7 current address is last plus one", int'(rbuf[0]), int'(model[11'h044]));
        mptr = 11'h045;
        // R8: sequential read of the full page
        rand_read(11'h040, 32, ok);
        cmp_read(11'h040, 32, "R8 sequential page read");

        // R8: wrap from the last array byte to 0
        wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
        write_tx(11'h7FE, 2, ok); wait_ready();
        wbuf[0] = 8'hF1; wbuf[1] = 8'hF2;
        write_tx(11'h000, 2, ok); wait_ready();
        rand_read(11'h7FE, 4, ok);
        cmp_read(11'h7FE, 4, "R8 read wraps to address 0");

        // R6: write protect
        wp = 1'b1;
        wbuf[0] = 8'hA5;
        write_tx(11'h123, 1, ok);
        chk(ok, "R6 data acked under protect", ok, 1);
        t_start(); send_byte(dev(0), a); t_stop();
        chk(a, "R6 no write cycle under protect", a, 1);
        wp = 1'b0;
        rand_read(11'h123, 1, ok);
        chk(rbuf[0] == 8'h5A, "R6 protected byte unchanged", int'(rbuf[0]), 8'h5A);

        // R10: dummy write loads the counter only
        addr_phase(16'h0050, ok); t_stop();
        t_start(); send_byte(dev(1), a);
        chk(a, "R10 no write cycle after dummy write", a, 1);
        read_body(1);
        chk(rbuf[0] === model[11'h050], "R10 counter loaded by dummy write", int'(rbuf[0]), int'(model[11'h050]));

        // R11: data followed by repeated start is dropped
        b = model[11'h050];
        addr_phase(16'h0050, ok);
        send_byte(8'hEE, a);
        t_start(); send_byte(dev(1), a);
        chk(a, "R11 repeated start read acked", a, 1);
        read_body(1);
        chk(rbuf[0] === model[11'h051], "R11 counter advanced past dropped byte", int'(rbuf[0]), int'(model[11'h051]));
        t_start(); send_byte(dev(0), a); t_stop();
        chk(a, "R11 no write cycle after repeated start", a, 1);
        rand_read(11'h050, 1, ok);
        chk(rbuf[0] === b, "R11 dropped byte not stored", int'(rbuf[0]), int'(b));

        // Random byte and short page writes with readback
        for (int it = 0; it < 10; it++) begin
            logic [AW-1:0] at;
            int n;
            at = AW'($urandom);
            n = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            write_tx(at, n, ok);
            chk(ok, "R4 random write acked", ok, 1);
            wait_ready();
            rand_read({at[AW-1:PW], {PW{1'b0}}}, 1 << PW, ok);
            cmp_read({at[AW-1:PW], {PW{1'b0}}}, 1 << PW, "R4 random page readback");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule